// File: doc/BRIEF.md
# Configurable SPI Serial Port

This block is a byte-wide SPI port that works either as the clock-driving master or as a slave that follows an external serial clock. Transmit data and receive data both pass through an 8-bit shift register. The byte received last is held in a single buffer register. Control inputs set the idle level of the clock, the clock edge on which data is launched, and, for the master, where in the bit time the input is sampled. In master mode the serial clock is the module clock divided by 4, 16 or 64.

A clock-enable input stands for a stopped peripheral clock. While it is low, a master byte stays frozen where it is and then picks up again without losing a bit. A slave keeps shifting while it is low, because the slave detects edges on the external clock it samples and does not depend on the enable. Status outputs report a full buffer, a write collision, a receive overflow and a completion interrupt flag. The flag has an enable, and the enable gates an interrupt/wake output. Software reads and writes the port through single-cycle strobes.

Top module: `spi_port`

## Requirements
- R1: The clock output idles at `cpol`. With `cke`=1 the clock keeps its idle level for the first half of each master bit time and then toggles at mid-bit. With `cke`=0 it leaves idle at the start of the bit time and returns at mid-bit. The four standard modes map as (0,0)=cpol0/cke1, (0,1)=cpol0/cke0, (1,0)=cpol1/cke1 and (1,1)=cpol1/cke0. Data is sent MSB first.
- R2: In master mode, `smp`=0 samples `sdi` at the middle of each bit time and `smp`=1 samples it at the end.
- R3: `div_sel` 0, 1 and 2 (and 3) give master bit times of 4, 16 and 64 (64) module clocks. `busy` falls 8×div+1 rising edges after the write strobe is taken.
- R4: While `clk_en` is low during a master byte, `sck_out`, `sdo` and `busy` hold steady. When the enable returns, the byte completes with correct data, late by exactly the number of stalled cycles.
- R5: In slave mode the port samples on the leading edge of `sck_in` when `cke`=1 and on the trailing edge when `cke`=0. It shifts its byte out on `sdo`, MSB first. It completes bytes even while `clk_en` is low.
- R6: Completion of a byte sets `irq_flag`. `irq_out` is high only while both `irq_flag` and `irq_en` are high. `irq_clr` clears the flag.
- R7: A completed byte is loaded into the buffer on `rd_data` and sets `buf_full`. An `rd_en` strobe clears `buf_full`.
- R8: A write strobe while a byte is in progress sets `wcol` and does not change the byte being shifted. `wcol_clr` clears `wcol`.
- R9: A byte that completes while `buf_full` is high sets `ovf` and leaves `rd_data` unchanged. `ovf_clr` clears `ovf`.
- R10: While `port_en` is low, `sck_out` equals `cpol`, `sdo` is 0, any byte in progress is dropped, and write strobes have no effect.
- R11: Reset aborts a byte in progress. After reset `busy`, `buf_full`, `wcol`, `ovf` and `irq_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Module clock enable for the master sequencer (low = halted) |
| port_en | input | 1 | Port enable |
| master | input | 1 | 1 = master, 0 = slave |
| cpol | input | 1 | Idle level of the serial clock |
| cke | input | 1 | Launch edge select (1 = data valid before the first edge) |
| smp | input | 1 | Master input sample point (0 = mid-bit, 1 = end of bit) |
| div_sel | input | 2 | Master clock divider select: 0 → /4, 1 → /16, 2 or 3 → /64 |
| irq_en | input | 1 | Interrupt enable |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | 8 | Transmit byte |
| rd_en | input | 1 | Buffer read strobe |
| wcol_clr | input | 1 | Clears the write-collision flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| irq_clr | input | 1 | Clears the interrupt flag |
| sck_in | input | 1 | External serial clock (slave) |
| sdi | input | 1 | Serial data in |
| sck_out | output | 1 | Serial clock out (master) |
| sdo | output | 1 | Serial data out |
| busy | output | 1 | Master byte in progress |
| rd_data | output | 8 | Receive buffer |
| buf_full | output | 1 | Buffer holds an unread byte |
| wcol | output | 1 | Write collision flag |
| ovf | output | 1 | Receive overflow flag |
| irq_flag | output | 1 | Byte-complete flag |
| irq_out | output | 1 | Interrupt/wake output |

## Verification
A master byte starts on the first rising edge after the write strobe. Its clock shape can be read at the next falling edge and at mid-bit. `busy` drops 8×div+1 edges later, plus one edge for each cycle the clock enable was held low. The bench counts falling edges from the write and compares that count against these figures. Status flags settle one edge after their cause, and the bench samples them at the following falling edge. Slave results pass through a two-stage synchronizer, so the bench holds each `sck_in` level for six module clocks and reads `sdo` just before the next sampling edge. A scoreboard monitor pops the expected byte the first time it sees `buf_full` high and then strobes `rd_en`.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  // counter width for the master bit-time sequencer (largest bit time 64)
  localparam int unsigned CNT_W = 6;

  typedef enum logic [1:0] {
    DIV_4  = 2'd0,
    DIV_16 = 2'd1,
    DIV_64 = 2'd2
  } div_sel_e;

  // half of the master bit time, in module clocks
  function automatic logic [CNT_W-1:0] half_period(input logic [1:0] sel);
    case (sel)
      DIV_4:   half_period = CNT_W'(2);
      DIV_16:  half_period = CNT_W'(8);
      default: half_period = CNT_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/spi_mclk_gen.sv
module spi_mclk_gen #(
  parameter int unsigned CNT_W = spi_port_pkg::CNT_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick,
  input  logic [1:0] div_sel,
  input  logic       cpol,
  input  logic       cke,
  output logic       sck,
  output logic       mid_stb,
  output logic       end_stb
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] half, last;

  always_comb begin
    half    = spi_port_pkg::half_period(div_sel);
    last    = (half << 1) - 1'b1;
    mid_stb = run & tick & (cnt_q == half - 1'b1);
    end_stb = run & tick & (cnt_q == last);
    if (!run)
      cnt_d = '0;
    else if (tick)
      cnt_d = (cnt_q == last) ? '0 : cnt_q + 1'b1;
    else
      cnt_d = cnt_q;
    if (!run)
      sck = cpol;
    else if (cke)
      sck = cpol ^ (cnt_q >= half);
    else
      sck = cpol ^ (cnt_q < half);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_sclk_sync.sv
module spi_sclk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic sdi,
  input  logic cpol,
  output logic lead_stb,
  output logic trail_stb,
  output logic sdi_s
);
  logic [STAGES-1:0] sck_sh, sdi_sh;
  logic              sck_prev;
  logic              sck_s;

  always_comb begin
    sck_s     = sck_sh[STAGES-1];
    sdi_s     = sdi_sh[STAGES-1];
    lead_stb  = (sck_s != sck_prev) & (sck_s != cpol);
    trail_stb = (sck_s != sck_prev) & (sck_s == cpol);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sh   <= '0;
      sdi_sh   <= '0;
      sck_prev <= 1'b0;
    end else begin
      sck_sh   <= {sck_sh[STAGES-2:0], sck_in};
      sdi_sh   <= {sdi_sh[STAGES-2:0], sdi};
      sck_prev <= sck_s;
    end
  end
endmodule

// File: rtl/spi_port.sv
module spi_port #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              port_en,
  input  logic              master,
  input  logic              cpol,
  input  logic              cke,
  input  logic              smp,
  input  logic [1:0]        div_sel,
  input  logic              irq_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              wcol_clr,
  input  logic              ovf_clr,
  input  logic              irq_clr,
  input  logic              sck_in,
  input  logic              sdi,
  output logic              sck_out,
  output logic              sdo,
  output logic              busy,
  output logic [DATA_W-1:0] rd_data,
  output logic              buf_full,
  output logic              wcol,
  output logic              ovf,
  output logic              irq_flag,
  output logic              irq_out
);
  localparam int unsigned CNT_W = spi_port_pkg::CNT_W;
  localparam int unsigned BIT_W = $clog2(DATA_W);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sh;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= '0;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_i = rst_sh[1];

  logic [DATA_W-1:0] sr_q, sr_d, buf_q, buf_d, new_byte;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic busy_q, busy_d, samp_q, samp_d;
  logic full_q, full_d, wcol_q, wcol_d, ovf_q, ovf_d, irq_q, irq_d;
  logic sck_m, mid_stb, end_stb;
  logic lead_stb, trail_stb, sdi_s;
  logic slv_on, slv_stb, xfer_act, wr_ok, wr_bad;
  logic shift_now, in_bit, last_bit, done;

  spi_mclk_gen #(.CNT_W(CNT_W)) u_mclk (
    .clk(clk), .rst_n(rst_i), .run(busy_q & port_en), .tick(clk_en),
    .div_sel(div_sel), .cpol(cpol), .cke(cke),
    .sck(sck_m), .mid_stb(mid_stb), .end_stb(end_stb)
  );

  spi_sclk_sync #(.STAGES(SYNC_STAGES)) u_ssync (
    .clk(clk), .rst_n(rst_i), .sck_in(sck_in), .sdi(sdi), .cpol(cpol),
    .lead_stb(lead_stb), .trail_stb(trail_stb), .sdi_s(sdi_s)
  );

  always_comb begin
    slv_on    = port_en & ~master;
    slv_stb   = slv_on & (cke ? lead_stb : trail_stb);
    xfer_act  = busy_q | (slv_on & (bit_q != '0));
    wr_ok     = wr_en & port_en & ~xfer_act;
    wr_bad    = wr_en & port_en & xfer_act;
    shift_now = port_en & (master ? end_stb : slv_stb);
    in_bit    = master ? (smp ? sdi : samp_q) : sdi_s;
    last_bit  = (bit_q == BIT_W'(DATA_W - 1));
    done      = shift_now & last_bit;
    new_byte  = {sr_q[DATA_W-2:0], in_bit};

    sr_d   = sr_q;
    bit_d  = bit_q;
    busy_d = busy_q;
    samp_d = samp_q;
    buf_d  = buf_q;
    full_d = full_q;
    wcol_d = wcol_q;
    ovf_d  = ovf_q;
    irq_d  = irq_q;

    if (mid_stb) samp_d = sdi;

    // shift engine
    if (!port_en) begin
      busy_d = 1'b0;
      bit_d  = '0;
    end else if (wr_ok) begin
      sr_d   = wr_data;
      bit_d  = '0;
      busy_d = master;
    end else if (shift_now) begin
      sr_d  = new_byte;
      bit_d = bit_q + 1'b1;
      if (last_bit) busy_d = 1'b0;
    end

    // status
    if (wcol_clr) wcol_d = 1'b0;
    if (wr_bad)   wcol_d = 1'b1;
    if (ovf_clr)  ovf_d  = 1'b0;
    if (irq_clr)  irq_d  = 1'b0;
    if (done) begin
      irq_d = 1'b1;
      if (full_q) begin
        ovf_d = 1'b1;
      end else begin
        buf_d  = new_byte;
        full_d = 1'b1;
      end
    end else if (rd_en) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      sr_q   <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
      samp_q <= 1'b0;
      buf_q  <= '0;
      full_q <= 1'b0;
      wcol_q <= 1'b0;
      ovf_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      bit_q  <= bit_d;
      busy_q <= busy_d;
      samp_q <= samp_d;
      buf_q  <= buf_d;
      full_q <= full_d;
      wcol_q <= wcol_d;
      ovf_q  <= ovf_d;
      irq_q  <= irq_d;
    end
  end

  assign sck_out  = (port_en & master) ? sck_m : cpol;
  assign sdo      = port_en & sr_q[DATA_W-1];
  assign busy     = busy_q;
  assign rd_data  = buf_q;
  assign buf_full = full_q;
  assign wcol     = wcol_q;
  assign ovf      = ovf_q;
  assign irq_flag = irq_q;
  assign irq_out  = irq_q & irq_en;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic              port_en,
  input logic              master,
  input logic              cpol,
  input logic              wr_en,
  input logic              rd_en,
  input logic              busy,
  input logic              sck_out,
  input logic              sdo,
  input logic              buf_full,
  input logic              wcol,
  input logic              ovf,
  input logic [DATA_W-1:0] rd_data
);
  // R10: a disabled port holds its lines idle
  assert_idle_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> (sck_out == cpol) && !sdo);

  // R4: a stalled master byte does not move
  assert_freeze_on_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clk_en && port_en && master) |=>
      (!port_en || ($stable(sck_out) && $stable(sdo) && busy)));

  // R8: a write during a byte flags a collision
  assert_collision_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy && port_en) |=> wcol);

  // R9: an overflow keeps the old buffer contents
  assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $stable(rd_data));

  // R7: buffer-full only falls after a read strobe
  assert_full_clears_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_full) |-> $past(rd_en));
endmodule

bind spi_port spi_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .port_en(port_en),
  .master(master), .cpol(cpol), .wr_en(wr_en), .rd_en(rd_en), .busy(busy),
  .sck_out(sck_out), .sdo(sdo), .buf_full(buf_full), .wcol(wcol),
  .ovf(ovf), .rd_data(rd_data)
);

// File: tb/sim_spi_port.sv
`timescale 1ns/1ps
module sim_spi_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en = 1'b1, port_en = 1'b1, master = 1'b1, cpol = 1'b0, cke = 1'b1, smp = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic irq_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic wcol_clr = 1'b0, ovf_clr = 1'b0, irq_clr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic bsck = 1'b0, bsdi = 1'b0;
  logic [1:0] sdi_sel = 2'd0;
  logic sck_out, sdo, busy, buf_full, wcol, ovf, irq_flag, irq_out, sdi;
  logic [7:0] rd_data;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic mon_on = 1'b1, finished = 1'b0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  assign sdi = (sdi_sel == 2'd0) ? sdo : (sdi_sel == 2'd1) ? sck_out : bsdi;

  spi_port u0 (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .port_en(port_en), .master(master),
    .cpol(cpol), .cke(cke), .smp(smp), .div_sel(div_sel), .irq_en(irq_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .wcol_clr(wcol_clr),
    .ovf_clr(ovf_clr), .irq_clr(irq_clr), .sck_in(bsck), .sdi(sdi),
    .sck_out(sck_out), .sdo(sdo), .busy(busy), .rd_data(rd_data),
    .buf_full(buf_full), .wcol(wcol), .ovf(ovf), .irq_flag(irq_flag), .irq_out(irq_out)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor: pops the expected byte when the buffer fills, then reads it (R7)
  always @(negedge clk) begin
    rd_en <= 1'b0;
    if (rst_n && mon_on && buf_full && !rd_en) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected byte", rd_data, 0);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        check(rd_data == e, "R7 received byte", rd_data, e);
      end
      rd_en <= 1'b1;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000 && !finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000", cyc);
      summary();
    end
  end

  // master byte driver; n = falling edges from the write until busy is low
  task automatic run_master(input logic [7:0] tx, input logic [7:0] exp_rx, input logic do_push,
                            input int stall_at, input int stall_len, output int n);
    logic s0, d0, stable;
    if (do_push) exp_q.push_back(exp_rx);
    @(negedge clk); wr_data = tx; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; n = 1;
    while (busy) begin
      if (n == stall_at) begin
        s0 = sck_out; d0 = sdo; stable = 1'b1; clk_en = 1'b0;
        repeat (stall_len) begin
          @(negedge clk); n++;
          if (sck_out !== s0 || sdo !== d0 || !busy) stable = 1'b0;
        end
        clk_en = 1'b1;
        check(stable, "R4 frozen during stall", stable, 1);
      end else begin
        @(negedge clk); n++;
      end
    end
    repeat (3) @(negedge clk);
  endtask

  // R1: clock shape at bit start and mid-bit for a mode
  task automatic sck_shape(input logic cp, input logic ck, input logic [7:0] tx);
    logic a, b;
    cpol = cp; cke = ck; div_sel = 2'd0; sdi_sel = 2'd0;
    repeat (2) @(negedge clk);
    check(sck_out == cp, "R1 idle level", sck_out, cp);
    exp_q.push_back(tx);
    @(negedge clk); wr_data = tx; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; a = sck_out;
    check(sdo == tx[7], "R1 msb first", sdo, tx[7]);
    repeat (2) @(negedge clk); b = sck_out;
    check(a == (cp ^ ~ck), "R1 clock at bit start", a, cp ^ ~ck);
    check(b == (cp ^ ck), "R1 clock at mid-bit", b, cp ^ ck);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(sck_out == cp, "R1 idle after byte", sck_out, cp);
  endtask

  // R5: slave byte with the module clock stopped
  task automatic slave_byte(input logic ck, input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] got;
    master = 1'b0; cpol = 1'b0; cke = ck; sdi_sel = 2'd2; bsck = 1'b0; clk_en = 1'b0;
    repeat (4) @(negedge clk);
    exp_q.push_back(rx);
    wr_data = tx; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      if (ck) begin
        bsdi = rx[i]; repeat (6) @(negedge clk);
        got[i] = sdo; bsck = 1'b1; repeat (6) @(negedge clk); bsck = 1'b0;
      end else begin
        bsck = 1'b1; bsdi = rx[i]; repeat (6) @(negedge clk);
        got[i] = sdo; bsck = 1'b0; repeat (6) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
    check(got == tx, "R5 slave shifted out", got, tx);
    check(irq_flag == 1'b1, "R5 slave completion flag", irq_flag, 1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    clk_en = 1'b1; master = 1'b1; sdi_sel = 2'd0;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(busy == 0 && buf_full == 0 && wcol == 0 && ovf == 0 && irq_flag == 0,
          "R11 reset state", {busy, buf_full, wcol, ovf, irq_flag}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 four modes
    sck_shape(1'b0, 1'b1, 8'hA5);
    sck_shape(1'b0, 1'b0, 8'h3C);
    sck_shape(1'b1, 1'b1, 8'h96);
    sck_shape(1'b1, 1'b0, 8'h0F);
    cpol = 1'b0; cke = 1'b1;

    // R2 sample point: sdi follows sck, so mid samples idle, end samples active
    sdi_sel = 2'd1; smp = 1'b0;
    run_master(8'h55, 8'h00, 1'b1, -1, 0, n);
    smp = 1'b1;
    run_master(8'h55, 8'hFF, 1'b1, -1, 0, n);
    smp = 1'b0; sdi_sel = 2'd0;

    // R3 divider
    div_sel = 2'd0; run_master(8'hC3, 8'hC3, 1'b1, -1, 0, n);
    check(n == 33, "R3 div4 length", n, 33);
    div_sel = 2'd1; run_master(8'h81, 8'h81, 1'b1, -1, 0, n);
    check(n == 129, "R3 div16 length", n, 129);
    div_sel = 2'd2; run_master(8'h7E, 8'h7E, 1'b1, -1, 0, n);
    check(n == 513, "R3 div64 length", n, 513);
    div_sel = 2'd0;

    // R4 stall mid-byte
    run_master(8'hB4, 8'hB4, 1'b1, 6, 20, n);
    check(n == 53, "R4 stalled byte length", n, 53);

    // R6 interrupt flag and enable
    check(irq_flag == 1'b1, "R6 flag after byte", irq_flag, 1);
    check(irq_out == 1'b0, "R6 wake masked", irq_out, 0);
    irq_en = 1'b1; #1;
    check(irq_out == 1'b1, "R6 wake enabled", irq_out, 1);
    @(negedge clk); irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    check(irq_flag == 1'b0 && irq_out == 1'b0, "R6 flag cleared", irq_flag, 0);
    irq_en = 1'b0;

    // R8 write collision
    exp_q.push_back(8'h3C);
    @(negedge clk); wr_data = 8'h3C; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    repeat (4) @(negedge clk);
    wr_data = 8'hFF; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    check(wcol == 1'b1, "R8 collision flagged", wcol, 1);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    wcol_clr = 1'b1; @(negedge clk); wcol_clr = 1'b0;
    check(wcol == 1'b0, "R8 collision cleared", wcol, 0);

    // R9 overflow
    mon_on = 1'b0;
    run_master(8'h11, 8'h11, 1'b0, -1, 0, n);
    run_master(8'h22, 8'h22, 1'b0, -1, 0, n);
    check(ovf == 1'b1, "R9 overflow flagged", ovf, 1);
    check(rd_data == 8'h11, "R9 old byte kept", rd_data, 8'h11);
    exp_q.push_back(8'h11);
    mon_on = 1'b1;
    repeat (3) @(negedge clk);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    check(ovf == 1'b0 && buf_full == 1'b0, "R9 overflow cleared", ovf, 0);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;

    // R10 disable mid-byte
    cpol = 1'b1;
    repeat (2) @(negedge clk);
    wr_data = 8'hFF; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    repeat (5) @(negedge clk);
    port_en = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && sck_out == 1'b1 && sdo == 1'b0, "R10 idle when disabled",
          {busy, sck_out, sdo}, 3'b010);
    wr_data = 8'hAA; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    repeat (2) @(negedge clk);
    check(busy == 0 && wcol == 0 && buf_full == 0 && irq_flag == 0, "R10 write ignored",
          {busy, wcol, buf_full, irq_flag}, 0);
    port_en = 1'b1; cpol = 1'b0;
    repeat (2) @(negedge clk);

    // R5 slave, both sampling edges
    slave_byte(1'b1, 8'hD2, 8'h4B);
    slave_byte(1'b0, 8'h69, 8'hE1);

    // R11 reset aborts a byte
    @(negedge clk); wr_data = 8'h77; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(busy == 0 && sck_out == 0 && buf_full == 0 && irq_flag == 0, "R11 abort on reset",
          {busy, sck_out, buf_full, irq_flag}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_master(8'h5A, 8'h5A, 1'b1, -1, 0, n);
    check(n == 33, "R11 clean byte after reset", n, 33);

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R7 all bytes seen", exp_q.size(), 0);
    summary();
  end
endmodule